// File: doc/BRIEF.md
# Count-Compare Interval Timer with Match Reload

This block is a processor-style interval timer. It is built from two 32-bit registers, a running counter and a match target, and both are reachable through a small single-cycle register port. While the timer is enabled, the counter advances by one on every clock. When the counter reaches the target value, the block sets a sticky terminal-count interrupt and restarts the counter from zero. The interrupt line stays high until software writes a new target value, which acknowledges the tick.

Two gates can halt counting. The first is a stop bit, bit 3 of a configuration word supplied by the surrounding core. The second is a deep power-down (coma) input. The light sleep state has no effect, and the timer keeps running through it. If the target is left at all ones, the counter passes through every 32-bit value before it returns to zero, so the block then works as a free-running clocksource.

Top module: `cct_top`

## Requirements
- R1: While reset is asserted, the counter reads 0, the target reads all ones and `tc_irq` is 0.
- R2: The register address selects the register: 0 is the counter and 1 is the target. Reads are combinational from `reg_addr`. Addresses 2 and 3 read as 0, and writes to them change nothing.
- R3: While enabled, the counter increases by one on every clock.
- R4: While bit 3 of `cfg_word` is 1, the counter holds its value. The other bits of `cfg_word` have no effect.
- R5: `pwr_sleep` has no effect on counting. While `pwr_coma` is 1, the counter holds its value.
- R6: If the counter equals the target on an enabled clock, the next cycle shows a counter of 0 and `tc_irq` at 1, and counting continues from there. No match is detected while counting is halted.
- R7: `tc_irq` stays at 1 until the target register is written. A write to the target clears it, unless a match is detected in that same cycle, in which case the flag stays at 1.
- R8: A counter write takes priority over both the increment and the match reload. A match in that same cycle still sets `tc_irq`.
- R9: Two counter writes must be at least one idle cycle apart. When writes are spaced this way, each write takes effect, and the later value is the one kept.
- R10: A counter that passes the target wraps from all ones to 0 without raising `tc_irq`. With the target at all ones, the wrap to 0 is itself the match, and it sets `tc_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| cfg_word | input | 32 | Configuration word; bit 3 stops the timer |
| pwr_sleep | input | 1 | Light sleep indication (timer keeps running) |
| pwr_coma | input | 1 | Deep power-down indication (timer halts) |
| tc_irq | output | 1 | Sticky terminal-count interrupt |

## Verification
The bound checker checks the per-cycle relations on every clock. It confirms that the counter increments when enabled and holds when halted, reloads to zero on a match, and takes the written value on a counter write. It also confirms that the flag stays set without a target write, clears after a target write, never rises without a match, and that counter writes are never issued back to back. The bench scenarios cover the rest. They check the register decode and the inert addresses, that the non-stop configuration bits and sleep are ignored, that a match is suppressed while stopped and occurs on release, and that a write collides correctly with a match. They also cover both wrap cases near the top of the 32-bit range.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned CCT_ADDR_W = 2;

  typedef enum logic [CCT_ADDR_W-1:0] {
    SEL_COUNT   = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_RSVD2   = 2'd2,
    SEL_RSVD3   = 2'd3
  } cct_sel_e;
endpackage

// File: rtl/cct_rst_sync.sv
module cct_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic stage_d;
    if (i == 0) begin : g_first
      assign stage_d = 1'b1;
    end else begin : g_next
      assign stage_d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else        stage_q[i] <= stage_d;
    end
  end

  assign rst_n_sync = stage_q[STAGES-1];
endmodule

// File: rtl/cct_gate.sv
module cct_gate #(
  parameter int unsigned CFG_W    = 32,
  parameter int unsigned STOP_BIT = 3
) (
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             pwr_sleep,
  input  logic             pwr_coma,
  output logic             run
);
  // Sleep keeps the timer alive; only the stop bit and coma halt it.
  logic unused_gate_inputs;
  assign unused_gate_inputs = ^{cfg_word, pwr_sleep};

  assign run = !cfg_word[STOP_BIT] && !pwr_coma;
endmodule

// File: rtl/cct_count.sv
module cct_count #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         match,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // Software write first, then match reload, then increment.
  always_comb begin
    cnt_d = cnt_q;
    if (wr)              cnt_d = wdata;
    else if (run && match) cnt_d = '0;
    else if (run)          cnt_d = cnt_q + W'(1);
  end

  assign cnt_en = wr | run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cct_compare.sv
module cct_compare #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cmp_q,
  output logic         match
);
  logic [W-1:0] cmp_d;

  always_comb begin
    cmp_d = cmp_q;
    if (wr) cmp_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cmp_q <= '1;
    else if (wr) cmp_q <= cmp_d;
  end

  assign match = (cnt == cmp_q);
endmodule

// File: rtl/cct_irq.sv
module cct_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_q
);
  logic irq_d;
  logic irq_en;

  // A match in the acknowledge cycle wins so no tick is lost.
  always_comb begin
    irq_d = irq_q;
    if (set)      irq_d = 1'b1;
    else if (clr) irq_d = 1'b0;
  end

  assign irq_en = set | clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end
endmodule

// File: rtl/cct_top.sv
module cct_top
  import cct_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CFG_W       = 32,
  parameter int unsigned STOP_BIT    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [CCT_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [CFG_W-1:0]      cfg_word,
  input  logic                  pwr_sleep,
  input  logic                  pwr_coma,
  output logic                  tc_irq
);
  logic              rst_n_sync;
  logic              run;
  logic              match;
  logic              cnt_wr;
  logic              cmp_wr;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] cmp_q;
  cct_sel_e          sel;

  assign sel    = cct_sel_e'(reg_addr);
  assign cnt_wr = reg_we && (sel == SEL_COUNT);
  assign cmp_wr = reg_we && (sel == SEL_COMPARE);

  cct_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cct_gate #(.CFG_W(CFG_W), .STOP_BIT(STOP_BIT)) u_gate (
    .cfg_word  (cfg_word),
    .pwr_sleep (pwr_sleep),
    .pwr_coma  (pwr_coma),
    .run       (run)
  );

  cct_count #(.W(DATA_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .run   (run),
    .match (match),
    .wr    (cnt_wr),
    .wdata (reg_wdata),
    .cnt_q (cnt_q)
  );

  cct_compare #(.W(DATA_W)) u_cmp (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .wr    (cmp_wr),
    .wdata (reg_wdata),
    .cnt   (cnt_q),
    .cmp_q (cmp_q),
    .match (match)
  );

  cct_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .set   (run & match),
    .clr   (cmp_wr),
    .irq_q (tc_irq)
  );

  always_comb begin
    unique case (sel)
      SEL_COUNT:   reg_rdata = cnt_q;
      SEL_COMPARE: reg_rdata = cmp_q;
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int unsigned W        = 32,
  parameter int unsigned CFG_W    = 32,
  parameter int unsigned STOP_BIT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_word,
  input logic             pwr_coma,
  input logic             cnt_wr,
  input logic             cmp_wr,
  input logic [W-1:0]     wdata,
  input logic [W-1:0]     cnt,
  input logic [W-1:0]     cmp,
  input logic             irq
);
  logic enabled;
  assign enabled = !cfg_word[STOP_BIT] && !pwr_coma;

  a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && !cnt_wr && cnt != cmp) |=> cnt == $past(cnt) + W'(1));

  a_r4_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[STOP_BIT] && !cnt_wr) |=> $stable(cnt));

  a_r5_coma_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_coma && !cnt_wr) |=> $stable(cnt));

  a_r6_match_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && !cnt_wr && cnt == cmp) |=> (cnt == '0) && irq);

  a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(enabled && cnt == cmp)) |=> !irq);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cmp_wr) |=> irq);

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !(enabled && cnt == cmp)) |=> !irq);

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(wdata));

  a_r9_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !cnt_wr);
endmodule

bind cct_top cct_checker #(
  .W(DATA_W), .CFG_W(CFG_W), .STOP_BIT(STOP_BIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .cfg_word (cfg_word),
  .pwr_coma (pwr_coma),
  .cnt_wr   (cnt_wr),
  .cmp_wr   (cmp_wr),
  .wdata    (reg_wdata),
  .cnt      (cnt_q),
  .cmp      (cmp_q),
  .irq      (tc_irq)
);

// File: tb/tb_cct_top.sv
module tb_cct_top;
  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] cfg_word;
  logic        pwr_sleep;
  logic        pwr_coma;
  logic        tc_irq;

  int checks;
  int fails;
  bit done;

  cct_top dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_word(cfg_word),
    .pwr_sleep(pwr_sleep), .pwr_coma(pwr_coma), .tc_irq(tc_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk_cnt(string req, logic [31:0] exp);
    logic [31:0] d;
    rd(2'd0, d);
    check(req, d, exp);
  endtask

  task automatic chk_irq(string req, logic exp);
    check(req, {31'd0, tc_irq}, {31'd0, exp});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); check("R1 count", d, 32'd0);
    rd(2'd1, d); check("R1 compare", d, 32'hFFFF_FFFF);
    chk_irq("R1 irq", 1'b0);
  endtask

  task automatic t_increment;
    cfg_word = 32'd0;
    wr(2'd0, 32'd100);
    repeat (7) @(negedge clk);
    chk_cnt("R3 increment", 32'd107);
  endtask

  task automatic t_stop;
    cfg_word = 32'h8;
    wr(2'd0, 32'd500);
    repeat (5) @(negedge clk);
    chk_cnt("R4 stop holds", 32'd500);
    cfg_word = 32'hFFFF_FFF7;
    repeat (4) @(negedge clk);
    chk_cnt("R4 other bits ignored", 32'd504);
    cfg_word = 32'd0;
  endtask

  task automatic t_power;
    pwr_sleep = 1'b1;
    wr(2'd0, 32'd1000);
    repeat (6) @(negedge clk);
    chk_cnt("R5 sleep runs", 32'd1006);
    pwr_sleep = 1'b0;
    wr(2'd1, 32'd5000);
    wr(2'd0, 32'd2000);
    pwr_coma = 1'b1;
    repeat (6) @(negedge clk);
    chk_cnt("R5 coma holds", 32'd2000);
    pwr_coma = 1'b0;
  endtask

  task automatic t_match;
    wr(2'd1, 32'd50);
    wr(2'd0, 32'd45);
    repeat (5) @(negedge clk);
    chk_cnt("R6 at target", 32'd50);
    chk_irq("R6 before match", 1'b0);
    @(negedge clk);
    chk_cnt("R6 reload", 32'd0);
    chk_irq("R6 irq set", 1'b1);
    @(negedge clk);
    chk_cnt("R6 restart", 32'd1);
  endtask

  task automatic t_sticky;
    repeat (20) @(negedge clk);
    chk_irq("R7 sticky", 1'b1);
    wr(2'd0, 32'd3);
    chk_irq("R7 count write no clear", 1'b1);
    cfg_word = 32'h8;
    @(negedge clk);
    chk_irq("R7 stop no clear", 1'b1);
    cfg_word = 32'd0;
    wr(2'd1, 32'd1000);
    chk_irq("R7 compare write clears", 1'b0);
  endtask

  task automatic t_priority;
    wr(2'd1, 32'd20);
    wr(2'd0, 32'd19);
    @(negedge clk);
    chk_cnt("R8 setup", 32'd20);
    wr(2'd0, 32'd7);
    chk_cnt("R8 write beats reload", 32'd7);
    chk_irq("R8 match still flags", 1'b1);
    @(negedge clk);
    chk_cnt("R8 continues", 32'd8);
    wr(2'd1, 32'd1000);
  endtask

  task automatic t_ack_race;
    wr(2'd1, 32'd30);
    wr(2'd0, 32'd29);
    @(negedge clk);
    wr(2'd1, 32'd30);
    chk_irq("R7 match beats ack", 1'b1);
    chk_cnt("R7 reload in race", 32'd0);
    wr(2'd1, 32'd30);
    chk_irq("R7 later ack clears", 1'b0);
  endtask

  task automatic t_wrap;
    wr(2'd1, 32'd10);
    wr(2'd0, 32'hFFFF_FFFE);
    @(negedge clk);
    chk_cnt("R10 near max", 32'hFFFF_FFFF);
    @(negedge clk);
    chk_cnt("R10 wrap", 32'd0);
    chk_irq("R10 wrap no irq", 1'b0);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'hFFFF_FFFD);
    @(negedge clk);
    @(negedge clk);
    chk_cnt("R10 at max", 32'hFFFF_FFFF);
    chk_irq("R10 before max match", 1'b0);
    @(negedge clk);
    chk_cnt("R10 max match reload", 32'd0);
    chk_irq("R10 max match irq", 1'b1);
    wr(2'd1, 32'd1000);
  endtask

  task automatic t_stopped_match;
    cfg_word = 32'h8;
    wr(2'd1, 32'd5);
    wr(2'd0, 32'd5);
    repeat (3) @(negedge clk);
    chk_cnt("R6 stopped no reload", 32'd5);
    chk_irq("R6 stopped no irq", 1'b0);
    cfg_word = 32'd0;
    @(negedge clk);
    chk_cnt("R6 release reload", 32'd0);
    chk_irq("R6 release irq", 1'b1);
    wr(2'd1, 32'd1000);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    cfg_word = 32'h8;
    wr(2'd0, 32'd77);
    wr(2'd2, 32'd123);
    wr(2'd3, 32'd456);
    rd(2'd0, d); check("R2 count kept", d, 32'd77);
    rd(2'd1, d); check("R2 compare kept", d, 32'd1000);
    rd(2'd2, d); check("R2 addr2 reads zero", d, 32'd0);
    rd(2'd3, d); check("R2 addr3 reads zero", d, 32'd0);
    cfg_word = 32'd0;
  endtask

  task automatic t_spacing;
    cfg_word = 32'h8;
    wr(2'd0, 32'd200);
    chk_cnt("R9 first write", 32'd200);
    @(negedge clk);
    wr(2'd0, 32'd300);
    chk_cnt("R9 later write kept", 32'd300);
    cfg_word = 32'd0;
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 32'd0;
    cfg_word = 32'd0; pwr_sleep = 1'b0; pwr_coma = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_increment();
    t_stop();
    t_power();
    t_match();
    t_sticky();
    t_priority();
    t_ack_race();
    t_wrap();
    t_stopped_match();
    t_decode();
    t_spacing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule